// File: doc/BRIEF.md
# Flash Block-Lock and Status Controller

This block is the command front end that sits between a CPU bus and an embedded flash array. The CPU writes a command byte together with a target block number in a single bus cycle. The controller decodes the command and checks it against a per-block protection bit. It then either starts a timed array operation or refuses the command on the spot. The flash array is represented by a busy counter whose outcome (pass or fail) is given by an input sampled when the command is accepted.

Each block carries one lock bit, and a lock bit of 0 protects that block. A global override input lifts every lock. An erase that passes while the override is set also clears the erased block's protection. A status byte reports ready, erase-error and program-error. A read-mode register selects what the single read port shows: the status byte, the lock bit of a latched block, or the array (which reads as zero here). The `rdy` pin follows the ready bit.

Top module: `flash_guard`

## Requirements
- R1: After reset `rdy` is 1, every lock bit is 1 (unlocked) and the read port is in array mode, so `rd_data` is 0x00. Once 0x70 is written, `rd_data` reads 0x80.
- R2: Command 0x77 runs a timed lock-program operation on block `cmd_blk`. If it passes, that block's lock bit becomes 0.
- R3: Command 0x71 latches `cmd_blk` and selects lock read mode. `rd_data` then equals {7'b0, lock bit of the latched block} and follows later changes to that bit.
- R4: With `lock_ovr`=0, erase (0x20) or program (0x40) on a block whose lock bit is 0 starts no operation. `rdy` stays 1, and in the next cycle status bit 5 (erase) or bit 4 (program) is 1.
- R5: With `lock_ovr`=1, erase and program start on any block, whatever its lock bit.
- R6: An erase that passes after being accepted with `lock_ovr`=1 sets the block's lock bit to 1. Any other erase or program leaves the lock bits unchanged.
- R7: Command 0x70 selects status read mode, and `rd_data` = {ready, 0, erase-err, program-err, 4'b0000}. Status mode is accepted even while busy.
- R8: Command 0x50 clears status bits 5 and 4 and does not change the read mode.
- R9: After an accepted operation, status bit 7 and `rdy` are 0 for exactly ERASE_CYC cycles (erase) or PROG_CYC cycles (program, lock-program), starting at the edge that accepts the command. They then return to 1.
- R10: `arr_fail` is sampled with an accepted command. A failing erase sets bit 5, and a failing program or lock-program sets bit 4. These bits stay set until 0x50 is written, and a failed operation does not change any lock bit.
- R11: While `rdy` is 0, every command other than 0x70 is ignored: lock bits, error bits and read mode do not change.
- R12: Any erase, program or lock-program command accepted while ready switches the read port to status mode. Command 0xFF selects array mode. Any other code is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one cycle per command |
| cmd_byte | input | 8 | Command code |
| cmd_blk | input | BLK_W | Target block number |
| lock_ovr | input | 1 | Global lock-disable control bit |
| arr_fail | input | 1 | Array outcome for the command being accepted (1 = fail) |
| rd_data | output | 8 | Read port: status, lock bit or array data |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
A wrong lock bit appears as soon as the block's lock is read with 0x71 or an erase or program is aimed at it. The command is then refused with an error bit, or it starts a busy period when it should not. A miscounted timer shows up on `rdy` at the cycle where the busy period should end. A mis-gated decoder shows up as a lock, mode or error change that follows a command written during busy. The bench compares `rdy` and `rd_data` with an independent model on every cycle, so each of these faults is reported on the first cycle it reaches the port.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {OP_ERASE, OP_PROG, OP_LOCK} op_kind_e;
  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_LOCK} rd_mode_e;

  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_LOCKPROG = 8'h77;
  localparam logic [7:0] CMD_RDLOCK   = 8'h71;
  localparam logic [7:0] CMD_RDSTAT   = 8'h70;
  localparam logic [7:0] CMD_CLRSTAT  = 8'h50;
  localparam logic [7:0] CMD_RDARRAY  = 8'hFF;

  // One strobe per recognised command, already gated by readiness
  typedef struct packed {
    logic erase;
    logic prog;
    logic lockprog;
    logic clrstat;
    logic rdstat;
    logic rdlock;
    logic rdarray;
  } cmd_strb_t;

  // A block may be altered when the override is on or its lock bit is 1
  function automatic logic may_alter(input logic ovr, input logic lock_bit);
    return ovr | lock_bit;
  endfunction

  // Status byte layout: bit7 ready, bit5 erase error, bit4 program error
  function automatic logic [7:0] pack_status(input logic ready, input logic e_err,
                                             input logic p_err);
    return {ready, 1'b0, e_err, p_err, 4'b0000};
  endfunction

  function automatic logic [7:0] pack_lock(input logic bit_v);
    return {7'b0000000, bit_v};
  endfunction

endpackage

// File: rtl/fg_cmd_dec.sv
module fg_cmd_dec
  import flash_guard_pkg::*;
(
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       ready,
  output cmd_strb_t  strb
);

  cmd_strb_t s;

  always_comb begin
    s = '0;
    if (cmd_we) begin
      // status read is always honoured; everything else needs ready
      if (cmd_byte == CMD_RDSTAT) begin
        s.rdstat = 1'b1;
      end else if (ready) begin
        case (cmd_byte)
          CMD_ERASE:    s.erase    = 1'b1;
          CMD_PROG:     s.prog     = 1'b1;
          CMD_LOCKPROG: s.lockprog = 1'b1;
          CMD_CLRSTAT:  s.clrstat  = 1'b1;
          CMD_RDLOCK:   s.rdlock   = 1'b1;
          CMD_RDARRAY:  s.rdarray  = 1'b1;
          default:      s = '0;
        endcase
      end
    end
  end

  assign strb = s;

  // At most one command strobe per cycle
  always_comb begin
    assert_one_strobe_R12: assert ($onehot0(strb));
  end

endmodule

// File: rtl/fg_lock_bank.sv
module fg_lock_bank #(
  parameter int NBLK  = 8,
  parameter int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en,
  input  logic [BLK_W-1:0] lock_blk,
  input  logic             unlock_en,
  input  logic [BLK_W-1:0] unlock_blk,
  input  logic [BLK_W-1:0] chk_blk,
  output logic             chk_bit,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             rd_bit,
  output logic [NBLK-1:0]  lock_vec
);

  logic [NBLK-1:0] bits_q;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic hit_lock, hit_unlock;
    assign hit_lock   = lock_en   && (lock_blk   == BLK_W'(g));
    assign hit_unlock = unlock_en && (unlock_blk == BLK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bits_q[g] <= 1'b1;
      else if (hit_lock)   bits_q[g] <= 1'b0;
      else if (hit_unlock) bits_q[g] <= 1'b1;
    end
  end

  assign chk_bit  = bits_q[chk_blk];
  assign rd_bit   = bits_q[rd_blk];
  assign lock_vec = bits_q;

  // Lock and unlock never target the same cycle (both come from one finishing op)
  always_comb begin
    if (rst_n) assert_no_dual_update_R6: assert (!(lock_en && unlock_en));
  end

endmodule

// File: rtl/fg_op_timer.sv
module fg_op_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= load;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Busy persists until the count reaches zero
  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done |=> busy_q);

  // Busy only ends through the terminal count
  assert_busy_ends_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done));

  // A start is never issued while already busy
  assert_no_start_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);

endmodule

// File: rtl/fg_status.sv
module fg_status
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       done,
  input  op_kind_e   done_kind,
  input  logic       done_fail,
  input  logic       refuse_erase,
  input  logic       refuse_prog,
  input  logic       clr,
  output logic [7:0] sr
);

  logic e_err_q, p_err_q;
  logic fail_erase, fail_prog;

  assign fail_erase = done && done_fail && (done_kind == OP_ERASE);
  assign fail_prog  = done && done_fail && (done_kind != OP_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_err_q <= 1'b0;
      p_err_q <= 1'b0;
    end else if (clr) begin
      e_err_q <= 1'b0;
      p_err_q <= 1'b0;
    end else begin
      if (refuse_erase || fail_erase) e_err_q <= 1'b1;
      if (refuse_prog  || fail_prog)  p_err_q <= 1'b1;
    end
  end

  assign sr = pack_status(!busy, e_err_q, p_err_q);

  assert_clear_errors_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sr[5:4] == 2'b00));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr[5] && !clr |=> sr[5]);

  assert_refuse_sets_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_prog |=> sr[4]);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int BLK_W     = (NBLK > 1) ? $clog2(NBLK) : 1,
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_byte,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             lock_ovr,
  input  logic             arr_fail,
  output logic [7:0]       rd_data,
  output logic             rdy
);

  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  cmd_strb_t        strb;
  logic             busy, op_done;
  logic             chk_bit, rd_bit;
  logic [NBLK-1:0]  lock_vec;
  logic [7:0]       sr;

  // internal events, named for the assertions
  logic             alter_ok, op_start, refuse_erase, refuse_prog;
  logic             ev_unlock, ev_lock;
  logic [CNT_W-1:0] load_val;

  op_kind_e         kind_q;
  logic [BLK_W-1:0] blk_q, rd_blk_q;
  logic             fail_q, ovr_q;
  rd_mode_e         mode_q;

  fg_cmd_dec u_dec (
    .cmd_we   (cmd_we),
    .cmd_byte (cmd_byte),
    .ready    (!busy),
    .strb     (strb)
  );

  assign alter_ok     = may_alter(lock_ovr, chk_bit);
  assign op_start     = ((strb.erase | strb.prog) & alter_ok) | strb.lockprog;
  assign refuse_erase = strb.erase & !alter_ok;
  assign refuse_prog  = strb.prog  & !alter_ok;
  assign load_val     = strb.erase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_ERASE;
      blk_q  <= '0;
      fail_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (op_start) begin
      kind_q <= strb.erase ? OP_ERASE : (strb.prog ? OP_PROG : OP_LOCK);
      blk_q  <= cmd_blk;
      fail_q <= arr_fail;
      ovr_q  <= lock_ovr;
    end
  end

  fg_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (op_start),
    .load  (load_val),
    .busy  (busy),
    .done  (op_done)
  );

  assign ev_unlock = op_done && (kind_q == OP_ERASE) && !fail_q && ovr_q;
  assign ev_lock   = op_done && (kind_q == OP_LOCK)  && !fail_q;

  fg_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_locks (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_en    (ev_lock),
    .lock_blk   (blk_q),
    .unlock_en  (ev_unlock),
    .unlock_blk (blk_q),
    .chk_blk    (cmd_blk),
    .chk_bit    (chk_bit),
    .rd_blk     (rd_blk_q),
    .rd_bit     (rd_bit),
    .lock_vec   (lock_vec)
  );

  fg_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (op_done),
    .done_kind    (kind_q),
    .done_fail    (fail_q),
    .refuse_erase (refuse_erase),
    .refuse_prog  (refuse_prog),
    .clr          (strb.clrstat),
    .sr           (sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= RD_ARRAY;
      rd_blk_q <= '0;
    end else if (strb.rdstat | strb.erase | strb.prog | strb.lockprog) begin
      mode_q <= RD_STATUS;
    end else if (strb.rdlock) begin
      mode_q   <= RD_LOCK;
      rd_blk_q <= cmd_blk;
    end else if (strb.rdarray) begin
      mode_q <= RD_ARRAY;
    end
  end

  always_comb begin
    case (mode_q)
      RD_STATUS: rd_data = sr;
      RD_LOCK:   rd_data = pack_lock(rd_bit);
      default:   rd_data = 8'h00;
    endcase
  end

  assign rdy = !busy;

  // Erase of a protected block without override: refused, stays ready, error shown
  assert_locked_erase_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && (cmd_byte == CMD_ERASE) && rdy && !lock_ovr && !lock_vec[cmd_blk]
    |=> rdy && rd_data[5]);

  // Passing lock-program leaves the target block locked
  assert_lockprog_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> !lock_vec[blk_q]);

  // Commands during busy (other than status read) change nothing
  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && (cmd_byte != CMD_RDSTAT) && !rdy && !op_done
    |=> $stable(lock_vec) && $stable(mode_q) && $stable(sr[5:4]));

  // A failed operation never changes a lock bit
  assert_fail_keeps_locks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && fail_q |=> $stable(lock_vec));

endmodule

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
  localparam int NBLK = 8;
  localparam int BW   = 3;
  localparam int ECYC = 12;
  localparam int PCYC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_we = 1'b0;
  logic [7:0]    cmd_byte = 8'h00;
  logic [BW-1:0] cmd_blk = '0;
  logic          lock_ovr = 1'b0;
  logic          arr_fail = 1'b0;
  logic [7:0]    rd_data;
  logic          rdy;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flash_guard #(.NBLK(NBLK), .BLK_W(BW), .ERASE_CYC(ECYC), .PROG_CYC(PCYC)) u_flash_guard (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte), .cmd_blk(cmd_blk),
    .lock_ovr(lock_ovr), .arr_fail(arr_fail), .rd_data(rd_data), .rdy(rdy)
  );

  // ---- reference model (0 erase, 1 program, 2 lock-program; mode 0 array, 1 status, 2 lock)
  bit m_lock [NBLK];
  bit m_busy, m_fail, m_ovr, m_e, m_p;
  int m_cnt, m_kind, m_blk, m_mode, m_rblk;

  function automatic logic [7:0] exp_rd();
    if (m_mode == 1) return {!m_busy, 1'b0, m_e, m_p, 4'b0000};
    if (m_mode == 2) return {7'b0, m_lock[m_rblk]};
    return 8'h00;
  endfunction

  task automatic model_edge(input bit we, input logic [7:0] code, input int blk,
                            input bit ovr, input bit fail);
    bit ready_before = !m_busy;
    if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy = 0;
        if (m_fail) begin
          if (m_kind == 0) m_e = 1; else m_p = 1;
        end else if (m_kind == 0 && m_ovr) m_lock[m_blk] = 1;
        else if (m_kind == 2) m_lock[m_blk] = 0;
      end else m_cnt--;
    end
    if (we) begin
      if (code == 8'h70) m_mode = 1;
      else if (ready_before) begin
        case (code)
          8'h20, 8'h40: begin
            m_mode = 1;
            if (ovr || m_lock[blk]) begin
              m_busy = 1; m_kind = (code == 8'h20) ? 0 : 1; m_blk = blk;
              m_fail = fail; m_ovr = ovr; m_cnt = (code == 8'h20) ? ECYC - 1 : PCYC - 1;
            end else if (code == 8'h20) m_e = 1;
            else m_p = 1;
          end
          8'h77: begin
            m_mode = 1; m_busy = 1; m_kind = 2; m_blk = blk;
            m_fail = fail; m_ovr = ovr; m_cnt = PCYC - 1;
          end
          8'h50: begin m_e = 0; m_p = 0; end
          8'h71: begin m_mode = 2; m_rblk = blk; end
          8'hFF: m_mode = 0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic check(input string tag);
    total++;
    if (rdy !== !m_busy) begin
      bad++;
      $display("FAIL %s rdy actual=%0b expected=%0b at %0t", tag, rdy, !m_busy, $time);
    end
    total++;
    if (rd_data !== exp_rd()) begin
      bad++;
      $display("FAIL %s rd_data actual=%02h expected=%02h at %0t", tag, rd_data, exp_rd(), $time);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] code, input int blk,
                      input bit ovr, input bit fail, input string tag);
    cmd_we = we; cmd_byte = code; cmd_blk = BW'(blk); lock_ovr = ovr; arr_fail = fail;
    @(posedge clk);
    model_edge(we, code, blk, ovr, fail);
    @(negedge clk);
    cmd_we = 1'b0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, tag);
  endtask

  initial begin
    #750us;
    bad++; total++;
    $display("FAIL R9 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] codes [8];
    codes = '{8'h20, 8'h40, 8'h77, 8'h71, 8'h70, 8'h50, 8'hFF, 8'h33};
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < NBLK; i++) m_lock[i] = 1;
    m_busy = 0; m_e = 0; m_p = 0; m_mode = 0; m_rblk = 0; m_cnt = 0;
    m_kind = 0; m_blk = 0; m_fail = 0; m_ovr = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset");
    step(1, 8'h70, 0, 0, 0, "R1 status after reset");
    step(1, 8'h71, 3, 0, 0, "R3 lock read unlocked");

    // lock-program block 3
    step(1, 8'h77, 3, 0, 0, "R2 lockprog start");
    idle(PCYC, "R9 lockprog busy window");
    step(1, 8'h71, 3, 0, 0, "R2 lock bit now 0");

    // refused erase / program on locked block
    step(1, 8'h20, 3, 0, 0, "R4 erase refused");
    step(1, 8'h40, 3, 0, 0, "R4 program refused");
    step(1, 8'h50, 0, 0, 0, "R8 clear errors");
    step(1, 8'h40, 3, 0, 0, "R4 program refused again");

    // busy window with ignored commands
    step(1, 8'h20, 5, 0, 0, "R9 erase start");
    step(1, 8'h50, 0, 0, 0, "R11 clear ignored");
    step(1, 8'h77, 5, 0, 0, "R11 lockprog ignored");
    step(1, 8'hFF, 0, 0, 0, "R11 array ignored");
    step(1, 8'h70, 0, 0, 0, "R7 status during busy");
    idle(ECYC, "R9 erase busy window");
    step(1, 8'h71, 5, 0, 0, "R6 plain erase keeps lock");

    // override erase of locked block removes its lock
    step(1, 8'h20, 3, 1, 0, "R5 override erase");
    idle(ECYC, "R9 override erase busy");
    step(1, 8'h71, 3, 0, 0, "R6 override erase unlocks");

    // failing operations
    step(1, 8'h50, 0, 0, 0, "R8 clear");
    step(1, 8'h77, 2, 0, 0, "R2 lock block 2");
    idle(PCYC, "R9");
    step(1, 8'h20, 2, 1, 1, "R10 failing override erase");
    idle(ECYC, "R10 erase fail bit5");
    step(1, 8'h40, 2, 1, 1, "R5 override program on locked");
    idle(PCYC, "R10 program fail bit4");
    step(1, 8'h71, 2, 0, 0, "R10 fail keeps lock");
    step(1, 8'h70, 0, 0, 0, "R10 errors sticky");
    step(1, 8'h33, 0, 0, 0, "R12 unknown ignored");
    step(1, 8'hFF, 0, 0, 0, "R12 array mode");
    step(1, 8'h40, 6, 0, 0, "R12 program selects status");
    idle(PCYC, "R9");

    // constrained random
    for (int n = 0; n < 1500; n++) begin
      bit we = ($urandom % 3) != 0;
      int blk = $urandom % NBLK;
      bit ovr = ($urandom % 4) == 0;
      bit fl  = ($urandom % 5) == 0;
      logic [7:0] c = codes[$urandom % 8];
      if (($urandom % 16) == 0) c = 8'($urandom);
      step(we, c, blk, ovr, fl, "R11 random mix");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule